// File: doc/BRIEF.md
# Radio Power-Up Sequencer

This block is the control state machine that takes a radio from one of its idle power levels into transmit or receive operation. Software, or a higher-level controller, holds a transmit request or a receive request. The sequencer then enables the regulators, the crystal oscillator, the PLL, VCO calibration, the power amplifier, the receive front end and the modem receive path in a fixed order. Three of the waits are paced by an internal down-counter: crystal start-up, PLL settling and PA ramp. Each wait takes a programmable cycle count. VCO calibration is the one step that waits on a handshake strobe from the analog side.

The current idle mode sets how far along the chain the radio already is, so a request enters the chain at the first step that is still needed. A configuration bit can remove VCO calibration from the path. Transmit ends when the packet engine signals completion. Either direction stops as soon as its request bit is withdrawn. All pins are plain control and status levels, and there is no streamed data path.

Top module: `radio_pwr_seq`

## Requirements
- R1: During and right after reset the state code is 0 (idle). With idle mode 0 all seven enable outputs are low.
- R2: In idle, the enables follow `idle_mode`. Value 0 turns everything off. Value 1 turns on the regulators only. Value 2 adds the crystal. Value 3 adds the PLL. The VCO-cal, PA, front-end and modem enables are always low in idle.
- R3: A request from idle enters the chain at a point set by the idle mode. Mode 0 goes to state 1 (regulator start), mode 1 to state 2 (crystal wait) and mode 2 to state 3 (PLL enable). Mode 3 goes to state 6 (PA ramp) for transmit or to state 8 (front-end enable) for receive.
- R4: The transmit chain uses state codes 1, 2, 3, 4, 5, 6 and then 7 (transmitting). Each state keeps every enable from earlier states on. Code 4 adds VCO-cal, and codes 6 and 7 add PA. VCO-cal is low in every other state.
- R5: The receive chain is identical up to code 5, then goes to code 8 (front end on) for one cycle, then to code 9 (front end and modem receive on). PA stays low throughout.
- R6: The crystal wait (2), PLL settle (5) and PA ramp (6) states each last N+1 cycles, where N is the value of `xtal_cycles`, `pll_cycles` or `pa_cycles` when the state is entered. A count of zero lasts exactly one cycle.
- R7: With `skip_cal` = 1, state 3 goes directly to state 5. With `skip_cal` = 0, state 3 goes to state 4, and state 4 holds until `cal_done` is sampled high.
- R8: If both request bits are high in idle, the transmit chain is taken.
- R9: If the request bit of the running direction is low at a clock edge, the state returns to idle (0) at that edge, from any non-idle state.
- R10: A `pkt_done` pulse in state 7 returns the block to idle at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Transmit request level |
| rx_req | input | 1 | Receive request level |
| skip_cal | input | 1 | 1 = bypass VCO calibration |
| idle_mode | input | 2 | Idle power level (0..3) |
| cal_done | input | 1 | VCO calibration finished strobe |
| pkt_done | input | 1 | Packet engine finished transmitting |
| xtal_cycles | input | CNT_W | Crystal start-up wait count |
| pll_cycles | input | CNT_W | PLL settle wait count |
| pa_cycles | input | CNT_W | PA ramp wait count |
| reg_en | output | 1 | Digital and analog regulator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| vco_cal_en | output | 1 | VCO calibration enable |
| pa_en | output | 1 | Power amplifier enable |
| rxfe_en | output | 1 | LNA, mixer and ADC enable |
| modem_rx_en | output | 1 | Modem receive mode enable |
| state_code | output | 4 | Current sequencer state |

## Verification
The assertions assume that `pkt_done` arrives only while transmitting and that request bits change only at clock-synchronous points. They also assume that `cal_done` is a strobe from the calibration logic and not a level the sequencer has to filter. The bench drives every input shortly after a falling edge. It raises `cal_done` only after a chosen number of cycles spent in the calibration state, and it keeps the three wait counts constant during each run, so every state length is fixed by the loaded count.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_REG_UP  = 4'd1,
    ST_XTAL    = 4'd2,
    ST_PLL_ON  = 4'd3,
    ST_VCO_CAL = 4'd4,
    ST_SETTLE  = 4'd5,
    ST_PA_RAMP = 4'd6,
    ST_TX_ON   = 4'd7,
    ST_RX_FE   = 4'd8,
    ST_RX_ON   = 4'd9
  } seq_state_e;

  typedef struct packed {
    logic regs;
    logic xtal;
    logic pll;
    logic vco_cal;
    logic pa;
    logic rxfe;
    logic modem;
  } seq_en_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/seq_enable_decode.sv
module seq_enable_decode
  import radio_seq_pkg::*;
(
  input  seq_state_e state,
  input  logic [1:0] idle_mode,
  output seq_en_t    en
);
  always_comb begin
    en = '0;
    unique case (state)
      ST_IDLE: begin
        en.regs = (idle_mode != 2'd0);
        en.xtal = idle_mode[1];
        en.pll  = (idle_mode == 2'd3);
      end
      ST_REG_UP:  en.regs = 1'b1;
      ST_XTAL:    begin en.regs = 1'b1; en.xtal = 1'b1; end
      ST_PLL_ON, ST_SETTLE: begin
        en.regs = 1'b1; en.xtal = 1'b1; en.pll = 1'b1;
      end
      ST_VCO_CAL: begin
        en.regs = 1'b1; en.xtal = 1'b1; en.pll = 1'b1; en.vco_cal = 1'b1;
      end
      ST_PA_RAMP, ST_TX_ON: begin
        en.regs = 1'b1; en.xtal = 1'b1; en.pll = 1'b1; en.pa = 1'b1;
      end
      ST_RX_FE: begin
        en.regs = 1'b1; en.xtal = 1'b1; en.pll = 1'b1; en.rxfe = 1'b1;
      end
      ST_RX_ON: begin
        en.regs = 1'b1; en.xtal = 1'b1; en.pll = 1'b1; en.rxfe = 1'b1;
        en.modem = 1'b1;
      end
      default: en = '0;
    endcase
  end
endmodule

// File: rtl/radio_pwr_seq.sv
module radio_pwr_seq
  import radio_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_req,
  input  logic             rx_req,
  input  logic             skip_cal,
  input  logic [1:0]       idle_mode,
  input  logic             cal_done,
  input  logic             pkt_done,
  input  logic [CNT_W-1:0] xtal_cycles,
  input  logic [CNT_W-1:0] pll_cycles,
  input  logic [CNT_W-1:0] pa_cycles,
  output logic             reg_en,
  output logic             xtal_en,
  output logic             pll_en,
  output logic             vco_cal_en,
  output logic             pa_en,
  output logic             rxfe_en,
  output logic             modem_rx_en,
  output logic [3:0]       state_code
);
  seq_state_e       state, nxt;
  logic             dir_tx, dir_tx_nxt;
  logic             tmr_load, tmr_done, active_req;
  logic [CNT_W-1:0] tmr_val;
  seq_en_t          en;

  assign active_req = dir_tx ? tx_req : rx_req;

  always_comb begin
    nxt        = state;
    dir_tx_nxt = dir_tx;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    unique case (state)
      ST_IDLE:
        if (tx_req || rx_req) begin
          dir_tx_nxt = tx_req;
          unique case (idle_mode)
            2'd0: nxt = ST_REG_UP;
            2'd1: begin nxt = ST_XTAL; tmr_load = 1'b1; tmr_val = xtal_cycles; end
            2'd2: nxt = ST_PLL_ON;
            default:
              if (tx_req) begin
                nxt = ST_PA_RAMP; tmr_load = 1'b1; tmr_val = pa_cycles;
              end else begin
                nxt = ST_RX_FE;
              end
          endcase
        end
      ST_REG_UP: begin nxt = ST_XTAL; tmr_load = 1'b1; tmr_val = xtal_cycles; end
      ST_XTAL:   if (tmr_done) nxt = ST_PLL_ON;
      ST_PLL_ON:
        if (skip_cal) begin
          nxt = ST_SETTLE; tmr_load = 1'b1; tmr_val = pll_cycles;
        end else begin
          nxt = ST_VCO_CAL;
        end
      ST_VCO_CAL:
        if (cal_done) begin
          nxt = ST_SETTLE; tmr_load = 1'b1; tmr_val = pll_cycles;
        end
      ST_SETTLE:
        if (tmr_done) begin
          if (dir_tx) begin
            nxt = ST_PA_RAMP; tmr_load = 1'b1; tmr_val = pa_cycles;
          end else begin
            nxt = ST_RX_FE;
          end
        end
      ST_PA_RAMP: if (tmr_done) nxt = ST_TX_ON;
      ST_TX_ON:   if (pkt_done) nxt = ST_IDLE;
      ST_RX_FE:   nxt = ST_RX_ON;
      ST_RX_ON:   nxt = ST_RX_ON;
      default:    nxt = ST_IDLE;
    endcase
    if (state != ST_IDLE && !active_req) begin
      nxt      = ST_IDLE;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dir_tx <= 1'b0;
    end else begin
      state  <= nxt;
      dir_tx <= dir_tx_nxt;
    end
  end

  seq_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  seq_enable_decode u_dec (
    .state     (state),
    .idle_mode (idle_mode),
    .en        (en)
  );

  assign reg_en      = en.regs;
  assign xtal_en     = en.xtal;
  assign pll_en      = en.pll;
  assign vco_cal_en  = en.vco_cal;
  assign pa_en       = en.pa;
  assign rxfe_en     = en.rxfe;
  assign modem_rx_en = en.modem;
  assign state_code  = state;
endmodule

// File: rtl/radio_pwr_seq_chk.sv
module radio_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_req,
  input logic       rx_req,
  input logic       skip_cal,
  input logic       pkt_done,
  input logic       reg_en,
  input logic       xtal_en,
  input logic       pll_en,
  input logic       vco_cal_en,
  input logic       pa_en,
  input logic       rxfe_en,
  input logic       modem_rx_en,
  input logic [3:0] state_code
);
  // R4
  pa_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> (pll_en && xtal_en && reg_en));

  // R5
  modem_needs_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modem_rx_en |-> rxfe_en);

  // R5
  pa_rx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_en && rxfe_en));

  // R7
  skip_bypasses_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd3 && skip_cal) |=> (state_code != 4'd4 && !vco_cal_en));

  // R9
  tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_code == 4'd6 || state_code == 4'd7) && !tx_req) |=> state_code == 4'd0);

  // R9
  rx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_code == 4'd8 || state_code == 4'd9) && !rx_req) |=> state_code == 4'd0);

  // R10
  pkt_done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd7 && pkt_done) |=> state_code == 4'd0);
endmodule

bind radio_pwr_seq radio_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
  .skip_cal(skip_cal), .pkt_done(pkt_done), .reg_en(reg_en),
  .xtal_en(xtal_en), .pll_en(pll_en), .vco_cal_en(vco_cal_en),
  .pa_en(pa_en), .rxfe_en(rxfe_en), .modem_rx_en(modem_rx_en),
  .state_code(state_code)
);

// File: tb/radio_pwr_seq_test.sv
`timescale 1ns/1ps
module radio_pwr_seq_test;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_req = 0, rx_req = 0, skip_cal = 0, cal_done = 0, pkt_done = 0;
  logic [1:0] idle_mode = 2'd0;
  logic [W-1:0] xtal_cycles = 0, pll_cycles = 0, pa_cycles = 0;
  logic reg_en, xtal_en, pll_en, vco_cal_en, pa_en, rxfe_en, modem_rx_en;
  logic [3:0] state_code;

  int errors = 0, checks = 0;
  int cal_delay = 0, cal_seen = 0;
  int lim = 1 << 30, pushed = 0;

  typedef struct { logic [3:0] st; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  radio_pwr_seq #(.CNT_W(W)) uut (.*);

  function automatic logic [6:0] exp_en(input logic [3:0] s, input logic [1:0] m);
    case (s)
      4'd0: return {m != 2'd0, m[1], m == 2'd3, 4'b0000};
      4'd1: return 7'b1000000;
      4'd2: return 7'b1100000;
      4'd3, 4'd5: return 7'b1110000;
      4'd4: return 7'b1111000;
      4'd6, 4'd7: return 7'b1110100;
      4'd8: return 7'b1110010;
      4'd9: return 7'b1110011;
      default: return 7'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] st);
    logic [6:0] act, exp;
    act = {reg_en, xtal_en, pll_en, vco_cal_en, pa_en, rxfe_en, modem_rx_en};
    exp = exp_en(st, idle_mode);
    checks++;
    if (state_code !== st || act !== exp) begin
      errors++;
      $display("FAIL %s: state=%0d en=%b expected state=%0d en=%b",
               tag, state_code, act, st, exp);
    end
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) if (q.size() > 0) begin
    item_t it;
    it = q.pop_front();
    check(it.tag, it.st);
  end

  // calibration handshake model (R7): cal_done after cal_delay cycles in state 4
  always @(negedge clk) begin
    if (state_code == 4'd4) begin
      cal_done = (cal_seen == cal_delay);
      cal_seen++;
    end else begin
      cal_done = 1'b0;
      cal_seen = 0;
    end
  end

  task automatic add(input logic [3:0] st, input int times, input string tag);
    for (int i = 0; i < times; i++)
      if (pushed < lim) begin
        item_t it;
        it.st = st; it.tag = tag;
        q.push_back(it);
        pushed++;
      end
  endtask

  task automatic run(input bit tx, input bit rx, input logic [1:0] mode,
                     input bit skip, input int cald, input int hold,
                     input int abort_at, input string tag);
    bit go_tx;
    int n;
    go_tx = tx;
    @(negedge clk); #1;
    idle_mode = mode; skip_cal = skip; cal_delay = cald;
    tx_req = tx; rx_req = rx;
    pushed = 0;
    lim = (abort_at > 0) ? abort_at : (1 << 30);
    if (mode == 2'd0) add(4'd1, 1, {tag, " R3 R4 start"});
    if (mode <= 2'd1) add(4'd2, xtal_cycles + 1, {tag, " R6 xtal"});
    if (mode <= 2'd2) begin
      add(4'd3, 1, {tag, " R3 pll"});
      if (!skip) add(4'd4, cald + 1, {tag, " R7 cal"});
      add(4'd5, pll_cycles + 1, {tag, " R6 settle"});
    end
    if (go_tx) begin
      add(4'd6, pa_cycles + 1, {tag, " R4 R6 R8 ramp"});
      add(4'd7, hold, {tag, " R4 tx"});
    end else begin
      add(4'd8, 1, {tag, " R5 fe"});
      add(4'd9, hold, {tag, " R5 rx"});
    end
    n = pushed;
    lim = 1 << 30;
    repeat (n) @(negedge clk);
    #1;
    if (go_tx && abort_at == 0) begin
      pkt_done = 1'b1;
      add(4'd0, 1, {tag, " R10 done"});
      @(negedge clk); #1;
      pkt_done = 1'b0; tx_req = 0; rx_req = 0;
      add(4'd0, 1, {tag, " R10 idle"});
      @(negedge clk);
    end else begin
      tx_req = 0; rx_req = 0;
      add(4'd0, 2, {tag, " R9 stop"});
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'd0);
    #1 rst_n = 1'b1;
    add(4'd0, 2, "R1 after reset");
    repeat (2) @(negedge clk);
    for (int m = 1; m < 4; m++) begin
      #1 idle_mode = m[1:0];
      add(4'd0, 2, "R2 idle mode");
      repeat (2) @(negedge clk);
    end
    xtal_cycles = 3; pll_cycles = 2; pa_cycles = 4;
    run(1, 0, 2'd0, 0, 2, 3, 0, "tx m0");
    run(0, 1, 2'd0, 0, 0, 3, 0, "rx m0");
    run(1, 0, 2'd1, 1, 0, 2, 0, "tx m1 skip");
    run(0, 1, 2'd2, 0, 3, 2, 0, "rx m2");
    run(1, 0, 2'd3, 0, 0, 2, 0, "tx m3");
    run(0, 1, 2'd3, 0, 0, 2, 0, "rx m3");
    run(1, 1, 2'd2, 1, 0, 2, 0, "both R8");
    run(0, 1, 2'd0, 0, 0, 2, 3, "abort rx R9");
    run(1, 0, 2'd2, 0, 5, 2, 3, "abort tx R9");
    xtal_cycles = 0; pll_cycles = 0; pa_cycles = 0;
    run(1, 0, 2'd0, 1, 0, 1, 0, "zero R6");
    run(0, 1, 2'd1, 0, 1, 2, 0, "zero rx R6");
    xtal_cycles = 7; pll_cycles = 5; pa_cycles = 6;
    run(1, 0, 2'd1, 0, 1, 2, 0, "long R6");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule